// File: doc/BRIEF.md
# Register Rename Map with Restart Checkpoint

This block renames architectural registers onto a larger pool of physical registers for an out-of-order core. When an instruction issues, its destination register gets a physical register that is currently unallocated, and its two source registers are translated through the map of the most recently issued state. The physical register file itself and operand wakeup live elsewhere. This block only manages names.

Two copies of the map are kept. The speculative map follows issue. The retired map follows commit, which happens in program order. When an instruction commits, the retired map takes its new physical register, and the physical register that the retired map held before for that architectural register goes back to the free pool. After a misspeculation, a single restart cycle overwrites the speculative map with the retired map. In the same cycle the free pool is recomputed as every physical register that the retired map does not reference. Issue needs no walk-back and no per-instruction undo record.

Top module: `rename_ckpt_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both maps, and only physical registers ARCH_REGS to PHYS_REGS-1 are free. With the default sizes, the first destination handed out is physical register 32.
- R2: While `issue_ready` is high, `issue_dst_phys` shows, combinationally, the lowest-numbered free physical register. An issue that fires removes that register from the free pool.
- R3: `issue_src0_phys` and `issue_src1_phys` are the speculative-map entries for the source registers. When a source equals the destination of the same issue, it returns the mapping from before that issue.
- R4: After an issue fires, later lookups of its destination architectural register return the newly assigned physical register.
- R5: `issue_ready` is low exactly when no physical register is free. An `issue_valid` while `issue_ready` is low changes neither map nor the free pool.
- R6: A commit (`commit_valid`, `commit_arch`, `commit_phys`) writes `commit_phys` into the retired map and returns the physical register that was previously retired for `commit_arch` to the free pool, where it can be allocated from the next cycle.
- R7: While `restart` is high, no issue fires. On the next cycle the speculative map equals the retired map, and that retired map includes a commit presented in the same cycle as the restart.
- R8: After a restart, the free pool holds exactly the physical registers that the retired map does not reference, and allocation continues from the lowest of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction asks to be renamed this cycle |
| issue_dst_arch | input | $clog2(ARCH_REGS) | Destination architectural register |
| issue_src0_arch | input | $clog2(ARCH_REGS) | First source architectural register |
| issue_src1_arch | input | $clog2(ARCH_REGS) | Second source architectural register |
| issue_ready | output | 1 | At least one physical register is free |
| issue_dst_phys | output | $clog2(PHYS_REGS) | Physical register assigned to the destination |
| issue_src0_phys | output | $clog2(PHYS_REGS) | Current mapping of the first source |
| issue_src1_phys | output | $clog2(PHYS_REGS) | Current mapping of the second source |
| commit_valid | input | 1 | The oldest instruction retires this cycle |
| commit_arch | input | $clog2(ARCH_REGS) | Destination architectural register of the retiring instruction |
| commit_phys | input | $clog2(PHYS_REGS) | Physical register assigned to it at issue |
| restart | input | 1 | Discard speculative state and restore the retired map |

## Verification
The hardest state to reach is a restart in the same cycle as a commit, after the pool has first been drained and then partly refilled by commits. The restored map and the rebuilt pool then both depend on that last commit. The stimulus issues until `issue_ready` falls, tries one issue while the pool is empty, retires the oldest renames in order so that freed low-numbered registers are reused first, and then raises `restart` together with a commit. A second restart, with `issue_valid` held high, shows that the issue is dropped. A reference model in the bench predicts every lookup and every allocation.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

   // Default geometry of the rename structure
   localparam int unsigned DEF_ARCH_REGS = 32;
   localparam int unsigned DEF_PHYS_REGS = 64;

   // Order in which a free physical register is chosen
   typedef enum logic {
      PICK_LOW  = 1'b0,
      PICK_HIGH = 1'b1
   } pick_e;

endpackage

// File: rtl/rcm_pick.sv
module rcm_pick
   import rcm_pkg::*;
#(
   parameter int unsigned N      = 64,
   parameter pick_e       POLICY = PICK_LOW,
   localparam int unsigned IW    = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);

   assign found = |req;

   generate
      if (POLICY == PICK_LOW) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) idx = IW'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) idx = IW'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rcm_map_table.sv
module rcm_map_table #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned VW      = 6,
   parameter int unsigned NRD     = 2,
   localparam int unsigned IW     = $clog2(ENTRIES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IW-1:0]          wr_idx,
   input  logic [VW-1:0]          wr_val,
   input  logic                   load_en,
   input  logic [ENTRIES*VW-1:0]  load_vec,
   input  logic [NRD*IW-1:0]      rd_idx,
   output logic [NRD*VW-1:0]      rd_val,
   output logic [ENTRIES*VW-1:0]  cur_vec
);

   logic [VW-1:0] map_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) map_q[i] <= VW'(i);
      end else if (load_en) begin
         for (int i = 0; i < ENTRIES; i++) map_q[i] <= load_vec[i*VW +: VW];
      end else if (wr_en) begin
         map_q[wr_idx] <= wr_val;
      end
   end

   generate
      for (genvar r = 0; r < NRD; r++) begin : g_rd
         assign rd_val[r*VW +: VW] = map_q[rd_idx[r*IW +: IW]];
      end
      for (genvar e = 0; e < ENTRIES; e++) begin : g_flat
         assign cur_vec[e*VW +: VW] = map_q[e];
      end
   endgenerate

   // R7
   bulk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> cur_vec == $past(load_vec));

   // R4
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !load_en) |=> map_q[$past(wr_idx)] == $past(wr_val));

endmodule

// File: rtl/rcm_free_pool.sv
module rcm_free_pool
   import rcm_pkg::*;
#(
   parameter int unsigned NPHYS  = 64,
   parameter int unsigned NARCH  = 32,
   parameter pick_e       POLICY = PICK_LOW,
   localparam int unsigned PW    = $clog2(NPHYS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_en,
   output logic [PW-1:0]         alloc_idx,
   output logic                  any_free,
   input  logic                  release_en,
   input  logic [PW-1:0]         release_idx,
   input  logic                  rebuild_en,
   input  logic [NARCH*PW-1:0]   rebuild_map
);

   logic [NPHYS-1:0] free_q, free_d, refs;

   always_comb begin
      refs = '0;
      for (int a = 0; a < NARCH; a++) refs[rebuild_map[a*PW +: PW]] = 1'b1;
   end

   always_comb begin
      if (rebuild_en) begin
         free_d = ~refs;
      end else begin
         free_d = free_q;
         if (alloc_en)   free_d[alloc_idx]   = 1'b0;
         if (release_en) free_d[release_idx] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NPHYS; i++) free_q[i] <= (i >= NARCH);
      end else begin
         free_q <= free_d;
      end
   end

   rcm_pick #(.N(NPHYS), .POLICY(POLICY)) u_pick (
      .req   (free_q),
      .found (any_free),
      .idx   (alloc_idx)
   );

   // R2
   grant_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> free_q[alloc_idx]);

   // R6
   release_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (release_en && !rebuild_en) |=> free_q[$past(release_idx)]);

   // R8
   rebuild_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rebuild_en |=> $countones(free_q) == NPHYS - NARCH);

endmodule

// File: rtl/rename_ckpt_map.sv
module rename_ckpt_map
   import rcm_pkg::*;
#(
   parameter int unsigned ARCH_REGS = DEF_ARCH_REGS,
   parameter int unsigned PHYS_REGS = DEF_PHYS_REGS,
   parameter pick_e       PICK      = PICK_LOW
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         issue_valid,
   input  logic [$clog2(ARCH_REGS)-1:0] issue_dst_arch,
   input  logic [$clog2(ARCH_REGS)-1:0] issue_src0_arch,
   input  logic [$clog2(ARCH_REGS)-1:0] issue_src1_arch,
   output logic                         issue_ready,
   output logic [$clog2(PHYS_REGS)-1:0] issue_dst_phys,
   output logic [$clog2(PHYS_REGS)-1:0] issue_src0_phys,
   output logic [$clog2(PHYS_REGS)-1:0] issue_src1_phys,
   input  logic                         commit_valid,
   input  logic [$clog2(ARCH_REGS)-1:0] commit_arch,
   input  logic [$clog2(PHYS_REGS)-1:0] commit_phys,
   input  logic                         restart
);

   localparam int unsigned AW = $clog2(ARCH_REGS);
   localparam int unsigned PW = $clog2(PHYS_REGS);
   localparam int unsigned MW = ARCH_REGS * PW;

   generate
      if (PHYS_REGS <= ARCH_REGS) begin : g_bad_size
         $error("PHYS_REGS must exceed ARCH_REGS");
      end
      if ((1 << AW) != ARCH_REGS || (1 << PW) != PHYS_REGS) begin : g_bad_pow2
         $error("register counts must be powers of two");
      end
   endgenerate

   logic          issue_fire;
   logic          release_en;
   logic [PW-1:0] alloc_idx;
   logic          any_free;
   logic [PW-1:0] retired_old;
   logic [MW-1:0] spec_vec, ret_vec, restore_vec;
   logic [2*PW-1:0] src_phys;

   assign issue_ready    = any_free;
   assign issue_fire     = issue_valid & any_free & ~restart;
   assign release_en     = commit_valid & ~restart;
   assign issue_dst_phys = alloc_idx;
   assign issue_src0_phys = src_phys[0 +: PW];
   assign issue_src1_phys = src_phys[PW +: PW];

   // Retired map as it stands after this cycle's commit
   generate
      for (genvar a = 0; a < ARCH_REGS; a++) begin : g_restore
         assign restore_vec[a*PW +: PW] =
            (commit_valid && commit_arch == AW'(a)) ? commit_phys : ret_vec[a*PW +: PW];
      end
   endgenerate

   rcm_map_table #(.ENTRIES(ARCH_REGS), .VW(PW), .NRD(2)) u_spec_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (issue_fire),
      .wr_idx   (issue_dst_arch),
      .wr_val   (alloc_idx),
      .load_en  (restart),
      .load_vec (restore_vec),
      .rd_idx   ({issue_src1_arch, issue_src0_arch}),
      .rd_val   (src_phys),
      .cur_vec  (spec_vec)
   );

   rcm_map_table #(.ENTRIES(ARCH_REGS), .VW(PW), .NRD(1)) u_ret_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (commit_valid),
      .wr_idx   (commit_arch),
      .wr_val   (commit_phys),
      .load_en  (1'b0),
      .load_vec ('0),
      .rd_idx   (commit_arch),
      .rd_val   (retired_old),
      .cur_vec  (ret_vec)
   );

   rcm_free_pool #(.NPHYS(PHYS_REGS), .NARCH(ARCH_REGS), .POLICY(PICK)) u_pool (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_en    (issue_fire),
      .alloc_idx   (alloc_idx),
      .any_free    (any_free),
      .release_en  (release_en),
      .release_idx (retired_old),
      .rebuild_en  (restart),
      .rebuild_map (restore_vec)
   );

   // R7
   maps_equal_after_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> spec_vec == ret_vec);

   // R5
   empty_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_ready && !commit_valid && !restart) |=> !issue_ready);

   // R5
   no_issue_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_ready && !restart) |=> $stable(spec_vec));

endmodule

// File: tb/rename_ckpt_map_test.sv
`timescale 1ns/1ps
module rename_ckpt_map_test;

   localparam int NA = 32;
   localparam int NP = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       issue_valid = 1'b0;
   logic [4:0] issue_dst_arch = '0, issue_src0_arch = '0, issue_src1_arch = '0;
   logic       issue_ready;
   logic [5:0] issue_dst_phys, issue_src0_phys, issue_src1_phys;
   logic       commit_valid = 1'b0;
   logic [4:0] commit_arch = '0;
   logic [5:0] commit_phys = '0;
   logic       restart = 1'b0;

   always #2.5 clk = ~clk;

   rename_ckpt_map uut (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_dst_arch(issue_dst_arch),
      .issue_src0_arch(issue_src0_arch), .issue_src1_arch(issue_src1_arch),
      .issue_ready(issue_ready), .issue_dst_phys(issue_dst_phys),
      .issue_src0_phys(issue_src0_phys), .issue_src1_phys(issue_src1_phys),
      .commit_valid(commit_valid), .commit_arch(commit_arch),
      .commit_phys(commit_phys), .restart(restart)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // Reference model built from the requirements
   logic [5:0]    m_spec [NA];
   logic [5:0]    m_ret  [NA];
   logic [NP-1:0] m_free;

   typedef struct {
      logic       ready;
      logic [5:0] dst;
      logic [5:0] s0;
      logic [5:0] s1;
      string      tag;
   } exp_t;

   typedef struct {
      logic [4:0] arch;
      logic [5:0] phys;
   } rec_t;

   exp_t exp_q[$];
   rec_t inflight[$];
   event sample_ev;

   function automatic int lowest_free();
      for (int i = 0; i < NP; i++) if (m_free[i]) return i;
      return 0;
   endfunction

   task automatic check(string tag, string what, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   // Monitor: pops expectations and compares with the outputs
   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "issue_ready", int'(issue_ready), int'(e.ready));
            if (e.ready) check(e.tag, "issue_dst_phys", int'(issue_dst_phys), int'(e.dst));
            check(e.tag, "issue_src0_phys", int'(issue_src0_phys), int'(e.s0));
            check(e.tag, "issue_src1_phys", int'(issue_src1_phys), int'(e.s1));
         end
      end
   end

   // Driver: one clock cycle of stimulus plus the predicted outputs
   task automatic step(input logic iv, input int d, input int s0, input int s1,
                       input logic cv, input logic rs, input string tag);
      exp_t e;
      rec_t c;
      logic rdy;
      int   pick;
      @(negedge clk);
      c.arch = '0; c.phys = '0;
      if (cv) c = inflight.pop_front();
      issue_valid = iv; issue_dst_arch = 5'(d);
      issue_src0_arch = 5'(s0); issue_src1_arch = 5'(s1);
      commit_valid = cv; commit_arch = c.arch; commit_phys = c.phys;
      restart = rs;
      rdy  = |m_free;
      pick = lowest_free();
      e.ready = rdy; e.dst = 6'(pick);
      e.s0 = m_spec[s0]; e.s1 = m_spec[s1]; e.tag = tag;
      exp_q.push_back(e);
      #1 ->sample_ev;
      // advance the model
      begin
         logic [5:0] old_ret;
         old_ret = m_ret[c.arch];
         if (cv) m_ret[c.arch] = c.phys;
         if (rs) begin
            for (int a = 0; a < NA; a++) m_spec[a] = m_ret[a];
            m_free = '1;
            for (int a = 0; a < NA; a++) m_free[m_ret[a]] = 1'b0;
            inflight.delete();
         end else begin
            if (iv && rdy) begin
               rec_t r;
               m_spec[d] = 6'(pick);
               m_free[pick] = 1'b0;
               r.arch = 5'(d); r.phys = 6'(pick);
               inflight.push_back(r);
            end
            if (cv) m_free[old_ret] = 1'b1;
         end
      end
      @(posedge clk);
      #0.5;
      issue_valid = 1'b0; commit_valid = 1'b0; restart = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      for (int a = 0; a < NA; a++) begin m_spec[a] = 6'(a); m_ret[a] = 6'(a); end
      for (int i = 0; i < NP; i++) m_free[i] = (i >= NA);
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state, identity map and first free register 32
      step(0, 0, 0, 31, 0, 0, "R1");
      step(0, 0, 17, 5, 0, 0, "R1");

      // R2 R3: rename where a source equals the destination
      step(1, 3, 3, 7, 0, 0, "R2/R3");
      // R4: the new mapping is seen by the next instruction
      step(1, 4, 3, 4, 0, 0, "R4");
      step(0, 0, 4, 3, 0, 0, "R4");

      // R2: drain the pool
      for (int k = 0; k < 30; k++) step(1, (k * 7 + 1) % 32, k % 32, (k + 5) % 32, 0, 0, "R2");

      // R5: empty pool, issue ignored
      step(0, 0, 10, 1, 0, 0, "R5");
      step(1, 10, 10, 3, 0, 0, "R5");
      step(0, 0, 10, 1, 0, 0, "R5");

      // R6: commits free the previously retired register
      step(0, 0, 3, 4, 1, 0, "R6");
      step(0, 0, 3, 4, 0, 0, "R6");
      step(0, 0, 3, 4, 1, 0, "R6");
      step(1, 20, 20, 3, 0, 0, "R6");
      step(0, 0, 20, 1, 0, 0, "R6");

      // R7: restart together with a commit
      step(0, 0, 1, 20, 1, 1, "R7");
      step(0, 0, 3, 4, 0, 0, "R7");
      step(0, 0, 1, 20, 0, 0, "R7");

      // R7: issue offered during restart is dropped
      step(1, 9, 9, 20, 0, 0, "R7");
      step(1, 9, 9, 2, 0, 1, "R7");
      step(0, 0, 9, 20, 0, 0, "R7");

      // R8: rebuilt pool, allocation from its lowest member
      step(1, 2, 2, 1, 0, 0, "R8");
      step(1, 6, 2, 6, 0, 0, "R8");
      step(1, 8, 6, 8, 0, 0, "R8");
      step(0, 0, 8, 2, 0, 0, "R8");

      repeat (2) @(posedge clk);
      summary();
   end

endmodule